// File: doc/BRIEF.md
# Mode-Detecting Serial Register Slave

This block is the slave end of a three-wire serial register port (enable, serial clock, serial data in) with one serial data-out pin. It holds a small file of 24-bit registers. After reset it watches the enable and clock inputs. Whichever shows a rising edge first chooses the framing protocol. That protocol then stays in force until the next reset.

In the enable-first protocol, a frame runs while enable is high. The first bit gives the direction. A 6-bit register address follows. For a write, 24 data bits come next and the register is updated when enable drops. For a read, the slave shifts the addressed register out on the following clocks.

In the clock-first protocol, data, register address and chip address are all clocked in while enable is low. A rising enable edge then commits the frame. Reads are indirect: register 0 holds a pointer, and each frame shifts out the register that the pointer selects. All three serial inputs are oversampled by the system clock through synchronisers, and every output is registered.

Top module: `dualmode_serial_slave`

## Requirements
- R1: The first rising edge seen after reset selects the protocol: enable-first if the enable edge comes first, clock-first if the serial clock edge comes first. The selection holds until reset, so frames of the other protocol change no register and drive no read data.
- R2: Enable-first write: while enable is high, serial bits are taken on rising serial-clock edges, MSB first, as a direction bit (0 = write), a 6-bit register address and 24 data bits, followed by one don't-care bit. The register is written on the falling enable edge.
- R3: Enable-first read (direction bit 1): after the 7th rising serial-clock edge, ser_dout shows bit 23 of the addressed register. Each later rising edge advances by one bit, so bit 0 is shown after the 30th edge.
- R4: Clock-first write: while enable is low, serial bits are taken on rising serial-clock edges, MSB first, as 24 data bits, a 5-bit register address and a 3-bit chip address. The write happens on the next rising enable edge.
- R5: A clock-first frame whose 3-bit chip address differs from the CHIP_ID parameter writes nothing.
- R6: In the clock-first protocol, bits [7:3] of register 0 form a read pointer. In the frame after any rising enable edge, ser_dout shows bit 23 of the pointed register after the 1st rising serial-clock edge and bit 0 after the 24th. A pointer written by a frame already applies to the frame that follows it.
- R7: A write frame with a clock count other than exactly 32 before its committing enable edge is discarded, in both protocols.
- R8: ser_dout is low in reset, before a protocol is chosen, during the address part of a read, and after the last of the 24 read bits.
- R9: Register addresses at or above REG_COUNT are not written, and reading them returns zero.
- R10: Serial clock edges are ignored while enable is low in the enable-first protocol and while enable is high in the clock-first protocol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Serial enable (asynchronous to clk) |
| ser_clk | input | 1 | Serial clock (asynchronous to clk) |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial read data out, registered |

## Verification
A wrong protocol choice, or a mode register that drifts, shows up in the next frame: either writes fail to land or read data appears on the wrong clock edge. A bit counter that is off by one shifts every read word by one position and stops writes from committing. Both faults are therefore visible on ser_dout within one or two frames. A bad read pointer shows a different register's contents in the frame right after the pointer write, and a wrong chip-address compare shows at the next readback of the target register.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_ENF  = 2'd1,
    MODE_CLKF = 2'd2
  } mode_e;
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= {pipe_q[STAGES-2:0], async_i[g]};
    end
    assign level_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/dss_regfile.sv
module dss_regfile #(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 24,
  parameter int ADDR_W  = 6,
  parameter int PTR_LSB = 3,
  parameter int PTR_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem_q[waddr[IDX_W-1:0]] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < DEPTH) ? mem_q[raddr[IDX_W-1:0]] : '0;
  assign ptr_o = mem_q[0][PTR_LSB +: PTR_W];
endmodule

// File: rtl/dss_engine.sv
module dss_engine import dss_pkg::*; #(
  parameter int DATA_W    = 24,
  parameter int EF_ADDR_W = 6,
  parameter int CF_ADDR_W = 5,
  parameter int CHIP_W    = 3,
  parameter int CHIP_ID   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_lvl,
  input  logic                 ck_lvl,
  input  logic                 din,
  input  logic [CF_ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0]    rf_rdata,
  output mode_e                mode_o,
  output logic                 rf_we,
  output logic [EF_ADDR_W-1:0] rf_waddr,
  output logic [EF_ADDR_W-1:0] rf_raddr,
  output logic [DATA_W-1:0]    rf_wdata,
  output logic                 dout
);
  localparam int EF_HDR = 1 + EF_ADDR_W;
  localparam int EF_LEN = EF_HDR + DATA_W + 1;
  localparam int CF_LEN = DATA_W + CF_ADDR_W + CHIP_W;
  localparam int SH_W   = (EF_LEN > CF_LEN) ? EF_LEN : CF_LEN;
  localparam int CNT_W  = $clog2(SH_W + 2);
  localparam int LEFT_W = $clog2(DATA_W + 1);

  mode_e             mode_q, mode_eff;
  logic              en_d, ck_d, load_q, dout_q;
  logic [SH_W-1:0]   sh_q, sh_next;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] out_sr_q;
  logic [LEFT_W-1:0] left_q;
  logic en_rise, en_fall, ck_rise, ef_clk, cf_clk, rd_start, ef_commit, cf_commit;

  assign en_rise = en_lvl & ~en_d;
  assign en_fall = ~en_lvl & en_d;
  assign ck_rise = ck_lvl & ~ck_d;

  always_comb begin
    mode_eff = mode_q;
    if (mode_q == MODE_NONE) begin
      if (en_rise)      mode_eff = MODE_ENF;
      else if (ck_rise) mode_eff = MODE_CLKF;
    end
  end

  assign sh_next  = {sh_q[SH_W-2:0], din};
  assign ef_clk   = (mode_eff == MODE_ENF) && ck_rise && en_lvl && !en_rise;
  assign cf_clk   = (mode_eff == MODE_CLKF) && ck_rise && !en_lvl;
  assign rd_start = ef_clk && (cnt_q == CNT_W'(EF_HDR - 1)) && sh_next[EF_HDR-1];

  assign ef_commit = (mode_q == MODE_ENF) && en_fall &&
                     (cnt_q == CNT_W'(EF_LEN)) && !sh_q[EF_LEN-1];
  assign cf_commit = (mode_q == MODE_CLKF) && en_rise && (cnt_q == CNT_W'(CF_LEN)) &&
                     (sh_q[CHIP_W-1:0] == CHIP_W'(CHIP_ID));

  assign rf_we    = ef_commit | cf_commit;
  assign rf_waddr = ef_commit ? sh_q[EF_LEN-2 -: EF_ADDR_W]
                              : EF_ADDR_W'(sh_q[CHIP_W +: CF_ADDR_W]);
  assign rf_wdata = ef_commit ? sh_q[1 +: DATA_W]
                              : sh_q[CHIP_W+CF_ADDR_W +: DATA_W];
  assign rf_raddr = (mode_eff == MODE_ENF) ? sh_next[EF_ADDR_W-1:0] : EF_ADDR_W'(ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_NONE;
      en_d     <= 1'b0;
      ck_d     <= 1'b0;
      load_q   <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
      out_sr_q <= '0;
      left_q   <= '0;
      dout_q   <= 1'b0;
    end else begin
      mode_q <= mode_eff;
      en_d   <= en_lvl;
      ck_d   <= ck_lvl;
      load_q <= 1'b0;
      if (en_rise) begin
        cnt_q  <= '0;
        sh_q   <= '0;
        left_q <= '0;
        dout_q <= 1'b0;
        load_q <= (mode_eff == MODE_CLKF);
      end else if (ef_clk || cf_clk) begin
        sh_q  <= sh_next;
        cnt_q <= cnt_q + CNT_W'(cnt_q != '1);
        if (rd_start) begin
          dout_q   <= rf_rdata[DATA_W-1];
          out_sr_q <= rf_rdata << 1;
          left_q   <= LEFT_W'(DATA_W - 1);
        end else if (left_q != '0) begin
          dout_q   <= out_sr_q[DATA_W-1];
          out_sr_q <= out_sr_q << 1;
          left_q   <= left_q - 1'b1;
        end else begin
          dout_q <= 1'b0;
        end
      end else if (en_fall && (mode_q == MODE_ENF)) begin
        left_q <= '0;
        dout_q <= 1'b0;
      end
      if (load_q) begin
        out_sr_q <= rf_rdata;
        left_q   <= LEFT_W'(DATA_W);
      end
    end
  end

  assign mode_o = mode_q;
  assign dout   = dout_q;
endmodule

// File: rtl/dualmode_serial_slave.sv
module dualmode_serial_slave import dss_pkg::*; #(
  parameter int REG_COUNT   = 8,
  parameter int DATA_W      = 24,
  parameter int EF_ADDR_W   = 6,
  parameter int CF_ADDR_W   = 5,
  parameter int CHIP_W      = 3,
  parameter int CHIP_ID     = 5,
  parameter int PTR_LSB     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_en,
  input  logic ser_clk,
  input  logic ser_din,
  output logic ser_dout
);
  logic [2:0]           sync_lvl;
  logic                 en_lvl, rf_we;
  logic [EF_ADDR_W-1:0] rf_waddr, rf_raddr;
  logic [DATA_W-1:0]    rf_wdata, rf_rdata;
  logic [CF_ADDR_W-1:0] rd_ptr;
  mode_e                mode_w;

  dss_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst),
    .async_i({ser_din, ser_clk, ser_en}),
    .level_o(sync_lvl)
  );

  assign en_lvl = sync_lvl[0];

  dss_engine #(
    .DATA_W(DATA_W), .EF_ADDR_W(EF_ADDR_W), .CF_ADDR_W(CF_ADDR_W),
    .CHIP_W(CHIP_W), .CHIP_ID(CHIP_ID)
  ) engine_i (
    .clk(clk), .rst(rst),
    .en_lvl(en_lvl), .ck_lvl(sync_lvl[1]), .din(sync_lvl[2]),
    .ptr(rd_ptr), .rf_rdata(rf_rdata),
    .mode_o(mode_w), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_raddr(rf_raddr), .rf_wdata(rf_wdata), .dout(ser_dout)
  );

  dss_regfile #(
    .DEPTH(REG_COUNT), .DATA_W(DATA_W), .ADDR_W(EF_ADDR_W),
    .PTR_LSB(PTR_LSB), .PTR_W(CF_ADDR_W)
  ) regs_i (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rf_raddr), .rdata(rf_rdata), .ptr_o(rd_ptr)
  );
endmodule

// File: rtl/dss_checker.sv
module dss_checker import dss_pkg::*; (
  input logic  clk,
  input logic  rst,
  input mode_e mode,
  input logic  en_lvl,
  input logic  rf_we,
  input logic  dout
);
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_NONE) |=> (mode == $past(mode))); // R1

  AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_NONE) |-> !dout); // R8

  AST_WRITE_AT_FRAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ((mode == MODE_ENF && $fell(en_lvl)) ||
               (mode == MODE_CLKF && $rose(en_lvl)))); // R2 R4

  AST_CF_QUIET_EN_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CLKF && en_lvl && $past(en_lvl)) |-> !dout); // R10

  AST_EF_QUIET_EN_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ENF && !en_lvl && !$past(en_lvl)) |-> !dout); // R10
endmodule

bind dualmode_serial_slave dss_checker chk_i (
  .clk(clk), .rst(rst), .mode(mode_w), .en_lvl(en_lvl),
  .rf_we(rf_we), .dout(ser_dout)
);

// File: tb/dualmode_serial_slave_tb_top.sv
module dualmode_serial_slave_tb_top;
  localparam int NREG = 8;
  localparam int HALF = 5;
  localparam logic [2:0] CHIP = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic ser_dout;
  int n_checks = 0, n_fails = 0;
  logic [23:0] model [NREG];

  always #10 clk = ~clk;

  dualmode_serial_slave #(.REG_COUNT(NREG), .CHIP_ID(5)) dut_i (
    .clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse(input logic d, output logic q);
    ser_clk = 1'b0; ser_din = d; tick(HALF);
    ser_clk = 1'b1; tick(HALF);
    q = ser_dout;
  endtask

  task automatic do_reset();
    ser_en = 0; ser_clk = 0; ser_din = 0; rst = 1;
    tick(4);
    rst = 0;
    tick(2);
    for (int i = 0; i < NREG; i++) model[i] = '0;
  endtask

  function automatic logic [23:0] pat_a(input int a);
    logic [31:0] t;
    t = (a + 1) * 32'h009E3779;
    return t[23:0] ^ 24'h5A5A5A;
  endfunction

  function automatic logic [23:0] pat_b(input int a);
    logic [31:0] t;
    t = (a + 7) * 32'h00C13FA9;
    return t[23:0] ^ 24'hA5C3F0;
  endfunction

  // enable-high frame: rw bit, 6-bit address, 24 data bits, pad bit
  task automatic ef_frame(input logic rw, input logic [5:0] a, input logic [23:0] d,
                          input int n, output logic [23:0] word, output logic quiet);
    logic [31:0] v;
    logic q;
    v = {rw, a, d, 1'b0};
    word = '0; quiet = 1'b1;
    ser_en = 1; tick(HALF);
    for (int i = 0; i < n; i++) begin
      pulse((i < 32) ? v[31-i] : 1'b0, q);
      if (i >= 6 && i < 30) word[29-i] = q;
      else if (q) quiet = 1'b0;
    end
    ser_clk = 0; tick(HALF);
    ser_en = 0; tick(HALF);
  endtask

  // enable-low frame: 24 data bits, 5-bit address, 3-bit chip address, then enable pulse
  task automatic cf_frame(input logic [23:0] d, input logic [4:0] a, input logic [2:0] chip,
                          input int n, output logic [23:0] word, output logic quiet);
    logic [31:0] v;
    logic q;
    v = {d, a, chip};
    word = '0; quiet = 1'b1;
    for (int i = 0; i < n; i++) begin
      pulse((i < 32) ? v[31-i] : 1'b0, q);
      if (i < 24) word[23-i] = q;
      else if (q) quiet = 1'b0;
    end
    ser_clk = 0; tick(HALF);
    ser_en = 1; tick(HALF);
    ser_en = 0; tick(HALF);
  endtask

  task automatic ef_read_chk(input string tag, input int a);
    logic [23:0] w;
    logic qt;
    ef_frame(1'b1, 6'(a), 24'h0, 32, w, qt);
    chk(tag, w, (a < NREG) ? model[a] : 24'h0);
    chk("R8 quiet outside read bits", 24'(qt), 24'h1);
  endtask

  task automatic cf_read_chk(input string tag, input int p);
    logic [23:0] w;
    logic qt;
    cf_frame(24'(p) << 3, 5'd0, CHIP, 32, w, qt);
    model[0] = 24'(p) << 3;
    cf_frame(24'hFFFFFF, 5'd1, CHIP ^ 3'b010, 32, w, qt);
    chk(tag, w, (p < NREG) ? model[p] : 24'h0);
    chk("R8 quiet after 24 read bits", 24'(qt), 24'h1);
  endtask

  initial begin
    logic [23:0] w;
    logic qt;

    // ---------- enable-first protocol ----------
    do_reset();
    chk("R8 reset output low", 24'(ser_dout), 24'h0);
    for (int a = 0; a < 64; a++) begin
      ef_frame(1'b0, 6'(a), pat_a(a), 32, w, qt);
      if (a < NREG) model[a] = pat_a(a);
    end
    for (int a = 0; a < 64; a++)
      ef_read_chk((a < NREG) ? "R2 R3 readback" : "R9 out-of-range read", a);
    ef_frame(1'b0, 6'd3, ~model[3], 31, w, qt);
    ef_read_chk("R7 short enable-first frame", 3);
    ef_frame(1'b0, 6'd5, ~model[5], 33, w, qt);
    ef_read_chk("R7 long enable-first frame", 5);
    cf_frame(24'h123456, 5'd4, CHIP, 32, w, qt);
    chk("R10 R1 clocks with enable low give no data", w, 24'h0);
    ef_read_chk("R1 R10 enable-low frame wrote nothing", 4);

    // ---------- clock-first protocol ----------
    do_reset();
    chk("R8 reset output low", 24'(ser_dout), 24'h0);
    for (int a = 0; a < 32; a++) begin
      cf_frame(pat_b(a), 5'(a), CHIP, 32, w, qt);
      if (a < NREG) model[a] = pat_b(a);
    end
    for (int p = 0; p < 32; p++)
      cf_read_chk((p < NREG) ? "R4 R6 pointer readback" : "R9 out-of-range pointer", p);
    cf_frame(~model[5], 5'd5, CHIP ^ 3'b001, 32, w, qt);
    cf_read_chk("R5 wrong chip address", 5);
    cf_frame(~model[6], 5'd6, CHIP, 31, w, qt);
    cf_read_chk("R7 short clock-first frame", 6);
    cf_frame(~model[6], 5'd6, CHIP, 33, w, qt);
    cf_read_chk("R7 long clock-first frame", 6);
    ef_frame(1'b0, 6'd2, ~model[2], 32, w, qt);
    chk("R10 R1 enable-high write frame output low", 24'(qt), 24'h1);
    ef_frame(1'b1, 6'd2, 24'h0, 32, w, qt);
    chk("R10 R1 enable-high read frame gives no data", w, 24'h0);
    cf_read_chk("R1 enable-high frames wrote nothing", 2);

    summary();
  end
endmodule